// File: doc/BRIEF.md
# Character Stream Generator for a Four-Line Text Display

This block produces the character codes for a text display of four lines with sixteen characters each. It walks the screen in row-major order, from line 0 column 0 through line 3 column 15. For each position it hands out one 8-bit ASCII code together with a valid strobe and the position's line and column index. A downstream display driver consumes the stream. That driver handles bus timing, enable pulses and initialisation. It asks for each following character with a one-cycle `next_char` pulse.

There are two pages of text. A select bit picks between them, and it is captured when a frame starts. The idle page holds fixed text only. The data page holds fixed text with two numeric fields. Each field shows an 8-bit input as three decimal digits, from 000 to 255. The rotor-speed field sits on line 0 and the road-speed field sits on line 1. The page select and both numeric inputs are captured at the accepted start of a frame, so every digit in one frame comes from the same sample.

Top module: `lcd_frame_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `char_valid` and `frame_done` are 0 and `line_idx`/`col_idx` are 0.
- R2: When `start` is high while `char_valid` is low, the next cycle shows `char_valid`=1 at line 0, column 0. A `start` while `char_valid` is high has no effect, and a `next_char` while idle has no effect.
- R3: While `char_valid` is high and `next_char` is low, `char_code`, `line_idx` and `col_idx` hold their values.
- R4: Each cycle with `char_valid` and `next_char` both high moves to the next position on the following cycle. The column rises by one, and after column 15 it goes back to 0 while the line rises by one.
- R5: Accepting `next_char` at line 3, column 15 drops `char_valid` on the next cycle. On that same cycle `frame_done` is high for exactly one cycle, and the indices return to 0,0.
- R6: Characters are ASCII codes. With page select 0 the four lines read `SYSTEM IDLE     `, `PRESS START     `, `* * * * * * * * ` and ` * * * * * * * *`. Column 0 is the leftmost character.
- R7: With page select 1 the lines read `ROTOR:000 RPM   `, `VELOC: 000 KM/H `, `TRIP:  --- KM   ` and `STATUS OK       `, except where a numeric field replaces the text.
- R8: On page 1, line 0, columns 6, 7 and 8 carry the hundreds, tens and units digits of `rpm_val`. Each digit is sent as 0x30 plus its value.
- R9: On page 1, line 1, columns 7, 8 and 9 carry the hundreds, tens and units digits of `speed_val`, coded the same way.
- R10: The page select and both numeric values are taken in the cycle that `start` is accepted. Changes to them during a frame do not alter that frame's characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new frame; accepted only when idle |
| next_char | input | 1 | Consumer has taken the current character |
| page_sel | input | 1 | 0 = idle page, 1 = data page |
| rpm_val | input | 8 | Rotor speed value, binary |
| speed_val | input | 8 | Road speed value, binary |
| char_code | output | 8 | ASCII code of the current position |
| char_valid | output | 1 | A character is being presented |
| line_idx | output | 2 | Line of the current character |
| col_idx | output | 4 | Column of the current character |
| frame_done | output | 1 | One-cycle pulse after the last character is taken |

## Verification
The assertions assume that `start` and `next_char` are ordinary synchronous levels. They place no limit on when either may rise: `next_char` may stay high across many positions, and `start` may be held during a frame. The stimulus stalls the consumer for random numbers of cycles and raises `start` in the middle of frames. It also changes the page select and both values while a frame runs. Boundary values 0, 9, 10, 99, 100 and 255 are driven directly, alongside seeded random values.

// File: rtl/lcd_frame_pkg.sv
package lcd_frame_pkg;
  localparam int LINES      = 4;
  localparam int COLS       = 16;
  localparam int LINE_W     = $clog2(LINES);
  localparam int COL_W      = $clog2(COLS);
  localparam int CHAR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int DIGITS     = 3;
  localparam int BCD_W      = 4 * DIGITS;
  localparam int NUM_FIELDS = 2;
  localparam int ROW_W      = COLS * CHAR_W;

  // field placement on the data page: field 0 = rotor, field 1 = road speed
  localparam int FLD_LINE [NUM_FIELDS] = '{0, 1};
  localparam int FLD_COL  [NUM_FIELDS] = '{6, 7};

  localparam logic [ROW_W-1:0] IDLE_R0 = "SYSTEM IDLE     ";
  localparam logic [ROW_W-1:0] IDLE_R1 = "PRESS START     ";
  localparam logic [ROW_W-1:0] IDLE_R2 = "* * * * * * * * ";
  localparam logic [ROW_W-1:0] IDLE_R3 = " * * * * * * * *";
  localparam logic [ROW_W-1:0] DATA_R0 = "ROTOR:000 RPM   ";
  localparam logic [ROW_W-1:0] DATA_R1 = "VELOC: 000 KM/H ";
  localparam logic [ROW_W-1:0] DATA_R2 = "TRIP:  --- KM   ";
  localparam logic [ROW_W-1:0] DATA_R3 = "STATUS OK       ";

  function automatic logic [CHAR_W-1:0] template_char(
    input logic              data_page,
    input logic [LINE_W-1:0] ln,
    input logic [COL_W-1:0]  cl
  );
    logic [ROW_W-1:0] row;
    case ({data_page, ln})
      3'b000:  row = IDLE_R0;
      3'b001:  row = IDLE_R1;
      3'b010:  row = IDLE_R2;
      3'b011:  row = IDLE_R3;
      3'b100:  row = DATA_R0;
      3'b101:  row = DATA_R1;
      3'b110:  row = DATA_R2;
      default: row = DATA_R3;
    endcase
    return row[CHAR_W*(COLS-1-int'(cl)) +: CHAR_W];
  endfunction
endpackage

// File: rtl/lcd_bin2bcd.sv
module lcd_bin2bcd #(
  parameter int DATA_W = 8,
  parameter int DIGITS = 3
) (
  input  logic [DATA_W-1:0]   bin,
  output logic [4*DIGITS-1:0] bcd
);
  localparam int SH_W = DATA_W + 4 * DIGITS;

  logic [SH_W-1:0] sh;

  always_comb begin
    sh = '0;
    sh[DATA_W-1:0] = bin;
    for (int i = 0; i < DATA_W; i++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (sh[DATA_W+4*d +: 4] >= 4'd5)
          sh[DATA_W+4*d +: 4] = sh[DATA_W+4*d +: 4] + 4'd3;
      end
      sh = sh << 1;
    end
    bcd = sh[DATA_W +: 4*DIGITS];
  end
endmodule

// File: rtl/lcd_pos_walker.sv
module lcd_pos_walker #(
  parameter int LINES = 4,
  parameter int COLS  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     next_char,
  output logic                     busy,
  output logic                     done,
  output logic [$clog2(LINES)-1:0] cur_line,
  output logic [$clog2(COLS)-1:0]  cur_col,
  output logic [$clog2(LINES)-1:0] nxt_line,
  output logic [$clog2(COLS)-1:0]  nxt_col,
  output logic                     start_acc,
  output logic                     load
);
  localparam int LW = $clog2(LINES);
  localparam int CW = $clog2(COLS);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);
  localparam logic [CW-1:0] LAST_COL  = CW'(COLS - 1);

  logic step, at_end, col_end;

  assign start_acc = start & ~busy;
  assign step      = busy & next_char;
  assign col_end   = (cur_col == LAST_COL);
  assign at_end    = col_end && (cur_line == LAST_LINE);
  assign load      = start_acc | (step & ~at_end);

  always_comb begin
    nxt_line = cur_line;
    nxt_col  = cur_col;
    if (start_acc) begin
      nxt_line = '0;
      nxt_col  = '0;
    end else if (col_end) begin
      nxt_line = cur_line + 1'b1;
      nxt_col  = '0;
    end else begin
      nxt_col  = cur_col + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cur_line <= '0;
      cur_col  <= '0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        busy     <= 1'b1;
        cur_line <= '0;
        cur_col  <= '0;
      end else if (step) begin
        if (at_end) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          cur_line <= '0;
          cur_col  <= '0;
        end else begin
          cur_line <= nxt_line;
          cur_col  <= nxt_col;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_char_select.sv
module lcd_char_select
  import lcd_frame_pkg::*;
(
  input  logic                                data_page,
  input  logic [LINE_W-1:0]                   ln,
  input  logic [COL_W-1:0]                    cl,
  input  logic [NUM_FIELDS-1:0][BCD_W-1:0]    fld_bcd,
  output logic [CHAR_W-1:0]                   code
);
  always_comb begin
    code = template_char(data_page, ln, cl);
    if (data_page) begin
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (int'(ln) == FLD_LINE[f] && int'(cl) >= FLD_COL[f] &&
            int'(cl) < FLD_COL[f] + DIGITS) begin
          code = {4'h3, fld_bcd[f][4*(DIGITS-1-(int'(cl)-FLD_COL[f])) +: 4]};
        end
      end
    end
  end
endmodule

// File: rtl/lcd_frame_gen.sv
module lcd_frame_gen
  import lcd_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              next_char,
  input  logic              page_sel,
  input  logic [DATA_W-1:0] rpm_val,
  input  logic [DATA_W-1:0] speed_val,
  output logic [CHAR_W-1:0] char_code,
  output logic              char_valid,
  output logic [LINE_W-1:0] line_idx,
  output logic [COL_W-1:0]  col_idx,
  output logic              frame_done
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] fld_in;
  logic [NUM_FIELDS-1:0][BCD_W-1:0]  bcd_now, bcd_q, bcd_use;
  logic                              page_q, page_use;
  logic [LINE_W-1:0]                 nxt_line;
  logic [COL_W-1:0]                  nxt_col;
  logic                              start_acc, load;
  logic [CHAR_W-1:0]                 code_next, char_q;

  assign fld_in[0] = rpm_val;
  assign fld_in[1] = speed_val;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_conv
    lcd_bin2bcd #(.DATA_W(DATA_W), .DIGITS(DIGITS)) u_conv (
      .bin (fld_in[g]),
      .bcd (bcd_now[g])
    );
  end

  lcd_pos_walker #(.LINES(LINES), .COLS(COLS)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .next_char (next_char),
    .busy      (char_valid),
    .done      (frame_done),
    .cur_line  (line_idx),
    .cur_col   (col_idx),
    .nxt_line  (nxt_line),
    .nxt_col   (nxt_col),
    .start_acc (start_acc),
    .load      (load)
  );

  assign page_use = start_acc ? page_sel : page_q;
  assign bcd_use  = start_acc ? bcd_now  : bcd_q;

  lcd_char_select u_sel (
    .data_page (page_use),
    .ln        (nxt_line),
    .cl        (nxt_col),
    .fld_bcd   (bcd_use),
    .code      (code_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= 1'b0;
      bcd_q  <= '0;
      char_q <= '0;
    end else begin
      if (start_acc) begin
        page_q <= page_sel;
        bcd_q  <= bcd_now;
      end
      if (load) char_q <= code_next;
    end
  end

  assign char_code = char_q;
endmodule

// File: rtl/lcd_frame_gen_chk.sv
module lcd_frame_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       next_char,
  input logic [7:0] char_code,
  input logic       char_valid,
  input logic [1:0] line_idx,
  input logic [3:0] col_idx,
  input logic       frame_done
);
  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (start && !char_valid) |=> (char_valid && line_idx == 2'd0 && col_idx == 4'd0)); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (char_valid && !next_char) |=> (char_valid && $stable(char_code) && $stable(line_idx) && $stable(col_idx))); // R3

  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (char_valid && next_char && col_idx != 4'd15) |=> (col_idx == $past(col_idx) + 4'd1 && line_idx == $past(line_idx))); // R4

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (char_valid && next_char && col_idx == 4'd15 && line_idx != 2'd3) |=> (col_idx == 4'd0 && line_idx == $past(line_idx) + 2'd1)); // R4

  AST_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    (char_valid && next_char && col_idx == 4'd15 && line_idx == 2'd3) |=> (frame_done && !char_valid && line_idx == 2'd0 && col_idx == 4'd0)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!char_valid && !start) |=> !char_valid); // R2
endmodule

bind lcd_frame_gen lcd_frame_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .next_char  (next_char),
  .char_code  (char_code),
  .char_valid (char_valid),
  .line_idx   (line_idx),
  .col_idx    (col_idx),
  .frame_done (frame_done)
);

// File: tb/tb_lcd_frame_gen.sv
`timescale 1ns/1ps
module tb_lcd_frame_gen;
  logic       clk = 1'b0;
  logic       rst, start, next_char, page_sel;
  logic [7:0] rpm_val, speed_val;
  logic [7:0] char_code;
  logic       char_valid, frame_done;
  logic [1:0] line_idx;
  logic [3:0] col_idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  lcd_frame_gen dut (
    .clk(clk), .rst(rst), .start(start), .next_char(next_char),
    .page_sel(page_sel), .rpm_val(rpm_val), .speed_val(speed_val),
    .char_code(char_code), .char_valid(char_valid), .line_idx(line_idx),
    .col_idx(col_idx), .frame_done(frame_done)
  );

  string idle_txt [4] = '{"SYSTEM IDLE     ", "PRESS START     ",
                          "* * * * * * * * ", " * * * * * * * *"};
  string data_txt [4] = '{"ROTOR:000 RPM   ", "VELOC: 000 KM/H ",
                          "TRIP:  --- KM   ", "STATUS OK       "};

  function automatic logic [7:0] digit_code(input int v, input int pos);
    int d;
    case (pos)
      0:       d = v / 100;
      1:       d = (v / 10) % 10;
      default: d = v % 10;
    endcase
    return 8'(48 + d);
  endfunction

  function automatic logic [7:0] exp_char(input bit pg, input int r, input int s,
                                          input int ln, input int cl);
    if (!pg) return idle_txt[ln][cl];
    if (ln == 0 && cl >= 6 && cl <= 8) return digit_code(r, cl - 6);
    if (ln == 1 && cl >= 7 && cl <= 9) return digit_code(s, cl - 7);
    return data_txt[ln][cl];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one complete frame; scramble changes inputs and raises start mid-frame
  task automatic do_frame(input bit pg, input int r, input int s, input bit scramble);
    @(negedge clk);
    page_sel = pg; rpm_val = 8'(r); speed_val = 8'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 64; k++) begin
      int ln = k / 16;
      int cl = k % 16;
      int stalls;
      logic [7:0] e;
      e = exp_char(pg, r, s, ln, cl);
      chk(char_valid === 1'b1, "R4 valid", int'(char_valid), 1);
      chk(line_idx == 2'(ln) && col_idx == 4'(cl), "R4 position",
          int'({line_idx, col_idx}), (ln << 4) | cl);
      if (pg && ((ln == 0 && cl >= 6 && cl <= 8)))
        chk(char_code == e, "R8 rotor digit", char_code, e);
      else if (pg && ((ln == 1 && cl >= 7 && cl <= 9)))
        chk(char_code == e, "R9 speed digit", char_code, e);
      else if (pg)
        chk(char_code == e, "R7 data text", char_code, e);
      else
        chk(char_code == e, "R6 idle text", char_code, e);
      if (scramble) begin
        page_sel  = ~pg;
        rpm_val   = 8'($urandom);
        speed_val = 8'($urandom);
        start     = 1'b1;           // R2: ignored while busy; R10 values frozen
      end
      stalls = int'($urandom % 3);
      for (int t = 0; t < stalls; t++) begin
        @(negedge clk);
        chk(char_valid === 1'b1 && char_code == e && col_idx == 4'(cl), "R3 hold",
            char_code, e);
      end
      next_char = 1'b1;
      @(negedge clk);
      next_char = 1'b0;
      start = 1'b0;
      if (scramble && k != 63)
        chk(char_code == exp_char(pg, r, s, (k+1)/16, (k+1)%16), "R10 frozen sample",
            char_code, exp_char(pg, r, s, (k+1)/16, (k+1)%16));
    end
    chk(char_valid === 1'b0 && frame_done === 1'b1, "R5 end of frame",
        int'({char_valid, frame_done}), 1);
    chk(line_idx == 2'd0 && col_idx == 4'd0, "R5 indices home",
        int'({line_idx, col_idx}), 0);
    @(negedge clk);
    chk(frame_done === 1'b0, "R5 single pulse", int'(frame_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; next_char = 1'b0; page_sel = 1'b0;
    rpm_val = '0; speed_val = '0;
    repeat (3) @(negedge clk);
    chk(char_valid === 1'b0 && frame_done === 1'b0, "R1 reset outputs",
        int'({char_valid, frame_done}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(char_valid === 1'b0 && line_idx == 2'd0 && col_idx == 4'd0, "R1 after reset",
        int'({char_valid, line_idx, col_idx}), 0);
    next_char = 1'b1;
    @(negedge clk);
    next_char = 1'b0;
    @(negedge clk);
    chk(char_valid === 1'b0 && frame_done === 1'b0, "R2 next while idle",
        int'({char_valid, frame_done}), 0);

    do_frame(1'b0, 0, 0, 1'b0);
    do_frame(1'b1, 0, 0, 1'b0);
    do_frame(1'b1, 255, 255, 1'b0);
    do_frame(1'b1, 9, 10, 1'b1);
    do_frame(1'b1, 100, 99, 1'b1);
    do_frame(1'b0, 123, 45, 1'b1);
    for (int i = 0; i < 10; i++)
      do_frame(1'($urandom), int'($urandom % 256), int'($urandom % 256), 1'($urandom));
    finish_run();
  end
endmodule